// File: doc/BRIEF.md
# Tone Code Output Latch with Host Handshake

This block sits between a tone classifier and a host. Each time the classifier strobes a new 4-bit tone code, the block either copies it into an output latch or, if the host is holding the outputs, parks it as a pending code. A change flag (`dchg`) tells the host that new data exists. In normal operation it is a pulse of fixed width that comes a fixed delay after the latch updates. If the host holds the outputs, the flag rises after a short delay and stays high until the hold is released. At that point the pending code is loaded and the flag drops a few cycles later.

An interrupt flag is set by a code change only while the host has the block unselected. Selecting the block clears it. The flag is brought out as a pull-down enable, so several sources can share one active-low request line. The data bus and the change flag are brought out with separate output enables that are active while the select input is low. All delays are counted in clock cycles.

The controller is a six-state machine:

- `ST_IDLE`: no flag activity.
- `ST_DELAY`: waits after a load.
- `ST_PULSE`: the flag is high for a fixed width.
- `ST_RISE`: waits before raising the flag under hold.
- `ST_HELD`: the flag is high while hold is low.
- `ST_FALL`: the flag stays high for a short tail after release.

The transitions are as follows:

- A strobe with hold high enters `ST_DELAY` from any state.
- A strobe with hold low enters `ST_RISE` from `ST_IDLE`, `ST_DELAY`, `ST_PULSE` or `ST_FALL`. In `ST_RISE` and `ST_HELD` it only replaces the pending code.
- `ST_DELAY` goes to `ST_PULSE`, and `ST_PULSE` goes to `ST_IDLE`, when their counts expire.
- `ST_RISE` goes to `ST_HELD` when its count expires.
- `ST_HELD` goes to `ST_FALL` when hold is seen high.
- `ST_FALL` goes to `ST_IDLE` when its count expires.

Top module: `tone_code_handshake`

## Requirements
- R1: A strobe sampled while `hold_n` is 1 loads `code_in` into `q_data` at that same clock edge.
- R2: After such a load, `dchg` stays 0 for DELAY_CYC cycles and is then 1 for exactly PULSE_CYC cycles.
- R3: While `hold_n` is 0, `q_data` does not change. A strobe under hold keeps `dchg` at 0 for RISE_CYC cycles, then drives it to 1 and keeps it at 1 for as long as `hold_n` stays 0.
- R4: When `hold_n` is seen at 1 in the held state, `q_data` takes the most recent code strobed under hold. `dchg` remains 1 for FALL_CYC more cycles and then goes to 0.
- R5: A strobe sampled while `cs_n` is 1 sets `irq_pull` to 1 at that edge, and it stays 1 while `cs_n` stays 1. A strobe while `cs_n` is 0 leaves `irq_pull` at 0.
- R6: `cs_n` sampled at 0 clears `irq_pull` to 0 at that edge.
- R7: `q_oe` and `dchg_oe` are 1 exactly when `cs_n` is 0.
- R8: Reset sets `q_data` to 4'b1110 (hex E) and holds `dchg` and `irq_pull` at 0. No `dchg` pulse follows reset without a strobe.
- R9: A strobe with `hold_n` at 1 that arrives during a pending delay or pulse restarts the timing. Only one pulse follows, timed from the latest strobe and carrying the latest code.
- R10: Driving `hold_n` low with no strobe causes no `dchg` activity and no change of `q_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, active high, synchronous |
| code_in | input | 4 | Tone code from the classifier |
| code_stb | input | 1 | One-cycle strobe marking a new code |
| hold_n | input | 1 | Hold request from the host, active low |
| cs_n | input | 1 | Chip select from the host, active low |
| q_data | output | 4 | Latched tone code |
| q_oe | output | 1 | Output enable for `q_data` |
| dchg | output | 1 | Data-change flag |
| dchg_oe | output | 1 | Output enable for `dchg` |
| irq_pull | output | 1 | 1 = pull the shared active-low request line low |

## Verification
The main function is driven with three patterns: a single strobe while hold is released, two strobes close together, and strobes under hold.

- The single strobe measures the delay and pulse width.
- The close pair tells a restarting timer from one that queues a second pulse.
- Strobes under hold, including a second strobe inside the held window, tell the frozen latch value apart from the pending code that appears on release.

The interrupt is exercised with strobes taken while unselected and while selected, followed by a select, which separates setting from clearing.

// File: rtl/tch_pkg.sv
package tch_pkg;

    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] RESET_CODE = 4'hE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_PULSE,
        ST_RISE,
        ST_HELD,
        ST_FALL
    } hs_state_t;

endpackage

// File: rtl/tch_timer.sv
module tch_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/tch_code_latch.sv
module tch_code_latch
    import tch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_new,
    input  logic              stash,
    input  logic              load_pend,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] q
);
    logic [CODE_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= RESET_CODE;
            pend_q <= RESET_CODE;
        end else begin
            if (load_new) begin
                q <= code_in;
            end else if (load_pend) begin
                q <= pend_q;
            end
            if (stash) begin
                pend_q <= code_in;
            end
        end
    end
endmodule

// File: rtl/tch_irq_flag.sv
module tch_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (clr_req) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/tone_code_handshake.sv
module tone_code_handshake
    import tch_pkg::*;
#(
    parameter int DELAY_CYC = 41,
    parameter int PULSE_CYC = 29,
    parameter int RISE_CYC  = 3,
    parameter int FALL_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_stb,
    input  logic              hold_n,
    input  logic              cs_n,
    output logic [CODE_W-1:0] q_data,
    output logic              q_oe,
    output logic              dchg,
    output logic              dchg_oe,
    output logic              irq_pull
);
    localparam int MAX_AB = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int MAX_CD = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW     = $clog2(MAX_C + 1);

    localparam logic [TW-1:0] LD_DELAY = TW'(DELAY_CYC - 1);
    localparam logic [TW-1:0] LD_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_RISE  = TW'(RISE_CYC - 1);
    localparam logic [TW-1:0] LD_FALL  = TW'(FALL_CYC - 1);

    hs_state_t     st_q, st_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          release_hold;
    logic          new_hold_free;
    logic          new_under_hold;

    assign new_hold_free  = code_stb && hold_n;
    assign new_under_hold = code_stb && !hold_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d         = st_q;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        release_hold = 1'b0;
        if (new_hold_free) begin
            st_d     = ST_DELAY;
            tmr_load = 1'b1;
            tmr_val  = LD_DELAY;
        end else if (new_under_hold && st_q != ST_RISE && st_q != ST_HELD) begin
            st_d     = ST_RISE;
            tmr_load = 1'b1;
            tmr_val  = LD_RISE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_DELAY: begin
                    if (tmr_done) begin
                        st_d     = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (tmr_done) st_d = ST_IDLE;
                end
                ST_RISE: begin
                    if (tmr_done) st_d = ST_HELD;
                end
                ST_HELD: begin
                    if (hold_n) begin
                        st_d         = ST_FALL;
                        tmr_load     = 1'b1;
                        tmr_val      = LD_FALL;
                        release_hold = 1'b1;
                    end
                end
                ST_FALL: begin
                    if (tmr_done) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dchg = 1'b0;
        unique case (st_q)
            ST_PULSE, ST_HELD, ST_FALL: dchg = 1'b1;
            ST_IDLE, ST_DELAY, ST_RISE: dchg = 1'b0;
            default:                    dchg = 1'b0;
        endcase
        q_oe    = !cs_n;
        dchg_oe = !cs_n;
    end

    tch_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    tch_code_latch latch_i (
        .clk       (clk),
        .rst       (rst),
        .load_new  (new_hold_free),
        .stash     (new_under_hold),
        .load_pend (release_hold),
        .code_in   (code_in),
        .q         (q_data)
    );

    tch_irq_flag irq_i (
        .clk     (clk),
        .rst     (rst),
        .set_req (code_stb && cs_n),
        .clr_req (!cs_n),
        .flag    (irq_pull)
    );
endmodule

// File: rtl/tch_checker.sv
module tch_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] code_in,
    input logic       code_stb,
    input logic       hold_n,
    input logic       cs_n,
    input logic [3:0] q_data,
    input logic       dchg,
    input logic       irq_pull
);
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        (code_stb && hold_n) |=> (q_data == $past(code_in)));

    a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
        !hold_n |=> $stable(q_data));

    a_r5_irq_set: assert property (@(posedge clk) disable iff (rst)
        (code_stb && cs_n) |=> irq_pull);

    a_r6_irq_clear: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> !irq_pull);

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        (code_stb && hold_n) |=> !dchg);
endmodule

bind tone_code_handshake tch_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .code_in  (code_in),
    .code_stb (code_stb),
    .hold_n   (hold_n),
    .cs_n     (cs_n),
    .q_data   (q_data),
    .dchg     (dchg),
    .irq_pull (irq_pull)
);

// File: tb/tone_code_handshake_tb_top.sv
module tone_code_handshake_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D = 6;
    localparam int P = 4;
    localparam int R = 3;
    localparam int F = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code_in = 4'h0;
    logic       code_stb = 1'b0;
    logic       hold_n = 1'b1;
    logic       cs_n = 1'b0;
    logic [3:0] q_data;
    logic       q_oe, dchg, dchg_oe, irq_pull;

    int check_cnt = 0;
    int fail_cnt  = 0;
    int rises     = 0;
    logic [3:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_code_handshake #(
        .DELAY_CYC(D), .PULSE_CYC(P), .RISE_CYC(R), .FALL_CYC(F)
    ) dut_i (
        .clk(clk), .rst(rst), .code_in(code_in), .code_stb(code_stb),
        .hold_n(hold_n), .cs_n(cs_n), .q_data(q_data), .q_oe(q_oe),
        .dchg(dchg), .dchg_oe(dchg_oe), .irq_pull(irq_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        check_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: optionally queues the code expected on q_data when dchg rises.
    task automatic send(input logic [3:0] code, input bit push, input logic [3:0] expv);
        if (push) exp_q.push_back(expv);
        code_in  = code;
        code_stb = 1'b1;
        @(negedge clk);
        code_stb = 1'b0;
    endtask

    task automatic wait_low(output int n);
        n = 0;
        while (!dchg && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_high(output int n);
        n = 0;
        while (dchg && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Monitor: pops the scoreboard on every rising dchg.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && dchg && !prev) begin
                rises++;
                if (exp_q.size() == 0) begin
                    check(0, "R8/R9 unexpected dchg pulse", 1, 0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(q_data == e, "R1/R3 code at dchg rise", q_data, e);
                end
            end
            prev = dchg;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
        $finish;
    end

    initial begin
        int lo, hi, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(q_data == 4'hE, "R8 reset code", q_data, 14);
        check(dchg == 1'b0, "R8 reset dchg", dchg, 0);
        check(irq_pull == 1'b0, "R8 reset irq", irq_pull, 0);
        check(q_oe && dchg_oe, "R7 enables with cs_n low", q_oe, 1);
        repeat (20) @(negedge clk);
        check(rises == 0, "R8 no pulse after reset", rises, 0);

        // R1, R2 single strobe with hold released
        send(4'h9, 1, 4'h9);
        check(q_data == 4'h9, "R1 load", q_data, 9);
        wait_low(lo);
        check(lo == D, "R2 delay", lo, D);
        wait_high(hi);
        check(hi == P, "R2 width", hi, P);

        // R9 restart
        r0 = rises;
        send(4'h1, 0, 4'h0);
        repeat (2) @(negedge clk);
        send(4'h2, 1, 4'h2);
        wait_low(lo);
        check(lo == D, "R9 delay from latest strobe", lo, D);
        wait_high(hi);
        check(hi == P, "R9 width", hi, P);
        check(rises == r0 + 1, "R9 single pulse", rises - r0, 1);

        // R10 hold with no strobe
        r0 = rises;
        hold_n = 1'b0;
        repeat (10) begin
            @(negedge clk);
            check(dchg == 1'b0 && q_data == 4'h2, "R10 quiet under hold", q_data, 2);
        end
        check(rises == r0, "R10 no pulse", rises - r0, 0);

        // R3, R4 strobe under hold
        send(4'h5, 1, 4'h2);
        check(q_data == 4'h2, "R3 frozen after strobe", q_data, 2);
        wait_low(lo);
        check(lo == R, "R3 rise delay", lo, R);
        repeat (6) @(negedge clk);
        send(4'h3, 0, 4'h0);
        repeat (6) @(negedge clk);
        check(dchg == 1'b1, "R3 dchg held high", dchg, 1);
        check(q_data == 4'h2, "R3 latch frozen", q_data, 2);
        hold_n = 1'b1;
        @(negedge clk);
        check(q_data == 4'h3, "R4 pending code on release", q_data, 3);
        wait_high(hi);
        check(hi == F, "R4 fall tail", hi, F);

        // R5, R6, R7 interrupt and enables
        cs_n = 1'b1;
        @(negedge clk);
        check(!q_oe && !dchg_oe, "R7 enables off with cs_n high", q_oe, 0);
        check(irq_pull == 1'b0, "R5 irq idle", irq_pull, 0);
        send(4'hA, 1, 4'hA);
        check(irq_pull == 1'b1, "R5 irq set", irq_pull, 1);
        wait_low(lo);
        wait_high(hi);
        check(irq_pull == 1'b1, "R5 irq stays latched", irq_pull, 1);
        cs_n = 1'b0;
        @(negedge clk);
        check(irq_pull == 1'b0, "R6 irq cleared by select", irq_pull, 0);
        check(q_oe && dchg_oe, "R7 enables back on", dchg_oe, 1);
        send(4'h7, 1, 4'h7);
        check(irq_pull == 1'b0, "R5 no irq while selected", irq_pull, 0);
        wait_low(lo);
        wait_high(hi);
        check(hi == P, "R2 width second pattern", hi, P);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
        $finish;
    end
endmodule